// File: doc/BRIEF.md
# PIO Timing Clock-Count Calculator

This block turns nanosecond targets for a programmed-I/O drive cycle into the clock counts that a disk controller's timing registers hold. Software or a sequencer gives it the wanted address-setup time, the wanted strobe-active time, the total cycle time, the period of the controller clock and a small revision number. It then returns the setup, active and recovery counts for that drive. It also returns the two register encodings: a 2-bit setup code and a byte that packs the active and recovery counts as nibbles.

Two drives can share one channel that has a single timing register set. In that case the caller sets `mate_present` and supplies the other drive's counts. The encodings then use the slower of each timing across the two drives, while the count outputs stay those of the requested drive. A request is launched with a one-cycle `start`. Four restoring divisions run one after another, one quotient bit per clock. A one-cycle `done` marks the moment the outputs take their new values.

Top module: `pio_clk_calc`

## Requirements
- R1: `setup_cnt` equals the ceiling of setup_ns / period_ns. The active and cycle base counts are rounded up in the same way.
- R2: The recovery base is the larger of two values. The first is the ceiling of max(cycle_ns − setup_ns − active_ns, 0) / period_ns. The second is max(C − S − A, 0), where C, S and A are the rounded-up cycle, setup and active counts.
- R3: The active base and the recovery base are each raised to at least 2.
- R4: A recovery value above 17 is set to 17, and the excess is added to the active count. After that, the active count is limited to 16.
- R5: When rev_id > 1, recovery is lowered by one after the step in R4. Recovery is then limited to 16.
- R6: After a successful request, `active_cnt` lies in 2..16 and `recov_cnt` lies in 1..16.
- R7: With `mate_present` = 1, the encodings use the larger of each count (setup, active, recovery) across this drive and the mate. With `mate_present` = 0, they use this drive's counts only.
- R8: `setup_code` encodes the merged setup count as follows: 4 gives 2'b00, 3 gives 2'b10, 1 or 2 gives 2'b01, and any other value gives 2'b11.
- R9: `drw_byte` carries the merged active count in bits 7:4 and the merged recovery count in bits 3:0. A count of 16 therefore appears as 0.
- R10: A request with period_ns = 0 performs no division. It raises `err` together with a `done` pulse and leaves all count and encoding outputs unchanged. The next valid request clears `err`.
- R11: After reset, all outputs are 0. `start` is taken only while `busy` is low. `done` lasts exactly one cycle, and the outputs change only in the cycle `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, taken when idle |
| setup_ns | input | 16 | Wanted address setup time |
| active_ns | input | 16 | Wanted strobe active time |
| cycle_ns | input | 16 | Wanted total cycle time |
| period_ns | input | 16 | Controller clock period |
| rev_id | input | 2 | Controller revision; values above 1 use the recovery-minus-one rule |
| mate_present | input | 1 | Channel mate exists; merge its counts into the encodings |
| mate_setup | input | 16 | Mate drive setup count |
| mate_active | input | 5 | Mate drive active count |
| mate_recov | input | 5 | Mate drive recovery count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request had a zero period |
| setup_cnt | output | 16 | Setup clocks for this drive |
| active_cnt | output | 5 | Active clocks for this drive |
| recov_cnt | output | 5 | Recovery count for this drive, revision adjusted |
| setup_code | output | 2 | Encoded merged setup count |
| drw_byte | output | 8 | Packed merged active and recovery nibbles |

## Verification
The hardest state to reach is the overflow path. A long cycle with a short clock period pushes recovery far past 17, moves the excess into the active count, and saturates both fields at once. Whether the result is right depends on how the cap and the revision adjustment are ordered. The sweep reaches this state by pairing a one-nanosecond period with cycle times of hundreds of nanoseconds, for both revision classes. It also uses setup and active targets larger than the cycle, which drive both recovery estimates to zero or below. A separate sequence overlaps a second `start` with a running request, to show that the second strobe is dropped.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} calc_state_t;

  // quotient plus one when the division left a remainder
  function automatic logic [31:0] ceil_adj(input logic [31:0] quot, input logic [31:0] rem);
    return (rem != 32'd0) ? quot + 32'd1 : quot;
  endfunction

  function automatic logic [1:0] setup_code_of(input logic [31:0] s);
    case (s)
      32'd4:         return 2'b00;
      32'd3:         return 2'b10;
      32'd1, 32'd2:  return 2'b01;
      default:       return 2'b11;
    endcase
  endfunction

  function automatic logic [31:0] max_u(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pio_div_restoring.sv
module pio_div_restoring #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]   q_r, r_r, d_lat, n_lat;
  logic [CNTW-1:0] cnt;
  logic           run;
  logic [W:0]     shifted;
  logic [W+1:0]   trial;
  logic           fits;

  assign shifted = {r_r, q_r[W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, d_lat};
  assign fits    = ~trial[W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0; r_r <= '0; d_lat <= '0; n_lat <= '0;
      cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else if (go) begin
      q_r   <= dividend;
      r_r   <= '0;
      d_lat <= divisor;
      n_lat <= dividend;
      cnt   <= CNTW'(W);
      run   <= 1'b1;
      done  <= 1'b0;
    end else if (run) begin
      r_r  <= fits ? trial[W-1:0] : shifted[W-1:0];
      q_r  <= {q_r[W-2:0], fits};
      cnt  <= cnt - 1'b1;
      run  <= (cnt != CNTW'(1));
      done <= (cnt == CNTW'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign quot = q_r;
  assign rem  = r_r;

  // R1: each division result satisfies the quotient/remainder identity
  a_r1_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((32'(quot) * 32'(d_lat) + 32'(rem)) == 32'(n_lat)) && (rem < d_lat));

endmodule

// File: rtl/pio_count_fold.sv
module pio_count_fold #(
  parameter int TW       = 16,
  parameter int CW       = 5,
  parameter int CNT_MIN  = 2,
  parameter int REC_FOLD = 17,
  parameter int FLD_MAX  = 16
) (
  input  logic [TW-1:0] s_base,
  input  logic [TW-1:0] a_base,
  input  logic [TW-1:0] c_base,
  input  logic [TW-1:0] r_time_base,
  input  logic          rev_hi,
  output logic [CW-1:0] active_o,
  output logic [CW-1:0] recov_o
);
  int r2, rec, act;

  always_comb begin
    r2 = int'(c_base) - int'(s_base) - int'(a_base);
    if (r2 < 0) r2 = 0;
    rec = (int'(r_time_base) > r2) ? int'(r_time_base) : r2;
    act = int'(a_base);
    if (act < CNT_MIN) act = CNT_MIN;
    if (rec < CNT_MIN) rec = CNT_MIN;
    if (rec > REC_FOLD) begin
      act = act + (rec - REC_FOLD);
      rec = REC_FOLD;
    end
    if (act > FLD_MAX) act = FLD_MAX;
    if (rev_hi) rec = rec - 1;
    if (rec > FLD_MAX) rec = FLD_MAX;
    active_o = act[CW-1:0];
    recov_o  = rec[CW-1:0];
  end

endmodule

// File: rtl/pio_reg_encode.sv
module pio_reg_encode #(
  parameter int TW = 16,
  parameter int CW = 5
) (
  input  logic [TW-1:0] own_setup,
  input  logic [CW-1:0] own_active,
  input  logic [CW-1:0] own_recov,
  input  logic          mate_on,
  input  logic [TW-1:0] mate_setup,
  input  logic [CW-1:0] mate_active,
  input  logic [CW-1:0] mate_recov,
  output logic [1:0]    code_o,
  output logic [7:0]    byte_o
);
  import pio_calc_pkg::*;

  logic [31:0] m_s, m_a, m_r;

  always_comb begin
    m_s = 32'(own_setup);
    m_a = 32'(own_active);
    m_r = 32'(own_recov);
    if (mate_on) begin
      m_s = max_u(m_s, 32'(mate_setup));
      m_a = max_u(m_a, 32'(mate_active));
      m_r = max_u(m_r, 32'(mate_recov));
    end
    code_o = setup_code_of(m_s);
    byte_o = {m_a[3:0], m_r[3:0]};
  end

endmodule

// File: rtl/pio_clk_calc.sv
module pio_clk_calc #(
  parameter int TW       = 16,
  parameter int CNT_MIN  = 2,
  parameter int REC_FOLD = 17,
  parameter int FLD_MAX  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   setup_ns,
  input  logic [15:0]   active_ns,
  input  logic [15:0]   cycle_ns,
  input  logic [15:0]   period_ns,
  input  logic [1:0]    rev_id,
  input  logic          mate_present,
  input  logic [15:0]   mate_setup,
  input  logic [4:0]    mate_active,
  input  logic [4:0]    mate_recov,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [15:0]   setup_cnt,
  output logic [4:0]    active_cnt,
  output logic [4:0]    recov_cnt,
  output logic [1:0]    setup_code,
  output logic [7:0]    drw_byte
);
  import pio_calc_pkg::*;

  localparam int CW   = $clog2(FLD_MAX + 1);
  localparam int NOPS = 4;
  localparam int IW   = $clog2(NOPS);

  calc_state_t   state;
  logic [TW-1:0] s_lat, a_lat, c_lat, p_lat, m_s_lat;
  logic [CW-1:0] m_a_lat, m_r_lat;
  logic          rev_hi_lat, m_on_lat;
  logic [IW-1:0] idx;
  logic          div_go, div_done;
  logic [TW-1:0] div_q, div_r, div_n;
  logic [TW-1:0] ceil_q [NOPS];
  logic [TW+1:0] rt;
  logic [TW-1:0] rec_dividend;
  logic [CW-1:0] fold_act, fold_rec;
  logic [1:0]    enc_code;
  logic [7:0]    enc_byte;
  logic          zero_period_req;
  logic [31:0]   ceil_now;

  assign rt = {2'b00, c_lat} - {2'b00, s_lat} - {2'b00, a_lat};
  assign rec_dividend = rt[TW+1] ? '0 : rt[TW-1:0];
  assign zero_period_req = (state == ST_IDLE) && start && (period_ns == '0);
  assign ceil_now = ceil_adj(32'(div_q), 32'(div_r));

  always_comb begin
    case (idx)
      2'd0:    div_n = s_lat;
      2'd1:    div_n = a_lat;
      2'd2:    div_n = c_lat;
      default: div_n = rec_dividend;
    endcase
  end

  pio_div_restoring #(.W(TW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_n), .divisor(p_lat),
    .done(div_done), .quot(div_q), .rem(div_r)
  );

  pio_count_fold #(.TW(TW), .CW(CW), .CNT_MIN(CNT_MIN), .REC_FOLD(REC_FOLD),
                   .FLD_MAX(FLD_MAX)) u_fold (
    .s_base(ceil_q[0]), .a_base(ceil_q[1]), .c_base(ceil_q[2]),
    .r_time_base(ceil_q[3]), .rev_hi(rev_hi_lat),
    .active_o(fold_act), .recov_o(fold_rec)
  );

  pio_reg_encode #(.TW(TW), .CW(CW)) u_enc (
    .own_setup(ceil_q[0]), .own_active(fold_act), .own_recov(fold_rec),
    .mate_on(m_on_lat), .mate_setup(m_s_lat), .mate_active(m_a_lat),
    .mate_recov(m_r_lat), .code_o(enc_code), .byte_o(enc_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      s_lat <= '0; a_lat <= '0; c_lat <= '0; p_lat <= '0;
      m_s_lat <= '0; m_a_lat <= '0; m_r_lat <= '0;
      rev_hi_lat <= 1'b0; m_on_lat <= 1'b0;
      idx <= '0; div_go <= 1'b0; done <= 1'b0; err <= 1'b0;
      for (int i = 0; i < NOPS; i++) ceil_q[i] <= '0;
      setup_cnt <= '0; active_cnt <= '0; recov_cnt <= '0;
      setup_code <= '0; drw_byte <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (zero_period_req) begin
            err  <= 1'b1;
            done <= 1'b1;
          end else if (start) begin
            err <= 1'b0;
            s_lat <= setup_ns; a_lat <= active_ns; c_lat <= cycle_ns;
            p_lat <= period_ns;
            rev_hi_lat <= (rev_id > 2'd1);
            m_on_lat <= mate_present;
            m_s_lat <= mate_setup; m_a_lat <= mate_active; m_r_lat <= mate_recov;
            idx    <= '0;
            div_go <= 1'b1;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (div_done) begin
            ceil_q[idx] <= ceil_now[TW-1:0];
            if (idx == IW'(NOPS - 1)) begin
              state <= ST_FIN;
            end else begin
              idx    <= idx + 1'b1;
              div_go <= 1'b1;
            end
          end
        end
        default: begin
          setup_cnt  <= ceil_q[0];
          active_cnt <= fold_act;
          recov_cnt  <= fold_rec;
          setup_code <= enc_code;
          drw_byte   <= enc_byte;
          done       <= 1'b1;
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R1: setup count is the smallest clock count covering the setup time
  a_r1_setup_ceil: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> (32'(setup_cnt) * 32'(p_lat) >= 32'(s_lat)) &&
                     ((setup_cnt == '0) || ((32'(setup_cnt) - 1) * 32'(p_lat) < 32'(s_lat))));

  // R6: active field range after a good request
  a_r6_active_range: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> (active_cnt >= CW'(CNT_MIN)) && (active_cnt <= CW'(FLD_MAX)));

  // R6: recovery field range after a good request
  a_r6_recov_range: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> (recov_cnt >= CW'(1)) && (recov_cnt <= CW'(FLD_MAX)));

  // R9: without a mate the packed byte mirrors this drive's own counts
  a_r9_pack_own: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && !m_on_lat |-> drw_byte == {active_cnt[3:0], recov_cnt[3:0]});

  // R10: a zero-period request leaves the results untouched
  a_r10_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> $stable(setup_cnt) && $stable(active_cnt) && $stable(recov_cnt) &&
                    $stable(drw_byte) && $stable(setup_code));

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: results move only together with done
  a_r11_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(setup_cnt) && $stable(active_cnt) && $stable(recov_cnt));

endmodule

// File: tb/pio_clk_calc_bench.sv
module pio_clk_calc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] setup_ns = '0, active_ns = '0, cycle_ns = '0, period_ns = '0;
  logic [1:0]  rev_id = '0;
  logic        mate_present = 1'b0;
  logic [15:0] mate_setup = '0;
  logic [4:0]  mate_active = '0, mate_recov = '0;
  logic busy, done, err;
  logic [15:0] setup_cnt;
  logic [4:0]  active_cnt, recov_cnt;
  logic [1:0]  setup_code;
  logic [7:0]  drw_byte;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pio_clk_calc u_pio_clk_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns), .period_ns(period_ns),
    .rev_id(rev_id), .mate_present(mate_present), .mate_setup(mate_setup),
    .mate_active(mate_active), .mate_recov(mate_recov),
    .busy(busy), .done(done), .err(err), .setup_cnt(setup_cnt),
    .active_cnt(active_cnt), .recov_cnt(recov_cnt), .setup_code(setup_code),
    .drw_byte(drw_byte)
  );

  // expected results
  int e_s, e_a, e_r, e_code, e_byte;

  function automatic int cdiv(int t, int p);
    return (t % p != 0) ? t / p + 1 : t / p;
  endfunction

  task automatic model(int s, int a, int c, int p, int rev, bit mp, int ms, int ma, int mr);
    int sc, ac, cc, r1, r2, rr, aa, msx, max_a, max_r;
    sc = cdiv(s, p); ac = cdiv(a, p); cc = cdiv(c, p);
    r1 = (c - s - a > 0) ? cdiv(c - s - a, p) : 0;
    r2 = cc - sc - ac; if (r2 < 0) r2 = 0;
    rr = (r1 > r2) ? r1 : r2;
    aa = (ac < 2) ? 2 : ac;
    if (rr < 2) rr = 2;
    if (rr > 17) begin aa = aa + rr - 17; rr = 17; end
    if (aa > 16) aa = 16;
    if (rev > 1) rr = rr - 1;
    if (rr > 16) rr = 16;
    e_s = sc; e_a = aa; e_r = rr;
    msx = sc; max_a = aa; max_r = rr;
    if (mp) begin
      if (ms > msx) msx = ms;
      if (ma > max_a) max_a = ma;
      if (mr > max_r) max_r = mr;
    end
    if (msx == 4) e_code = 0;
    else if (msx == 3) e_code = 2;
    else if (msx == 1 || msx == 2) e_code = 1;
    else e_code = 3;
    e_byte = (max_a % 16) * 16 + (max_r % 16);
  endtask

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic drive(int s, int a, int c, int p, int rev, bit mp, int ms, int ma, int mr);
    setup_ns = 16'(s); active_ns = 16'(a); cycle_ns = 16'(c); period_ns = 16'(p);
    rev_id = 2'(rev); mate_present = mp;
    mate_setup = 16'(ms); mate_active = 5'(ma); mate_recov = 5'(mr);
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin seen = 1'b1; break; end
    end
    if (!seen) begin
      checks++; errors++;
      $display("FAIL R11: done not seen, actual=0 expected=1");
    end
  endtask

  task automatic run_chk(int s, int a, int c, int p, int rev, bit mp, int ms, int ma, int mr);
    bit seen;
    @(negedge clk);
    drive(s, a, c, p, rev, mp, ms, ma, mr);
    start = 1'b1;
    wait_done(seen);
    model(s, a, c, p, rev, mp, ms, ma, mr);
    chk("R1 setup_cnt", int'(setup_cnt), e_s);
    chk("R3 R4 active_cnt", int'(active_cnt), e_a);
    chk("R2 R5 recov_cnt", int'(recov_cnt), e_r);
    chk("R8 setup_code", int'(setup_code), e_code);
    chk("R9 drw_byte", int'(drw_byte), e_byte);
    chk("R6 range", int'(active_cnt >= 2 && active_cnt <= 16 && recov_cnt >= 1 && recov_cnt <= 16), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit seen;
    int ps [4] = '{1, 3, 7, 30};
    int cs [5] = '{0, 50, 120, 383, 600};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset err", int'(err), 0);
    chk("R11 reset outputs", int'(setup_cnt) + int'(active_cnt) + int'(recov_cnt) +
        int'(setup_code) + int'(drw_byte), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // near-exhaustive sweep, no mate (R1..R6, R8, R9)
    foreach (ps[pi])
      foreach (cs[ci])
        for (int rev = 1; rev <= 2; rev++)
          for (int s = 0; s <= 40; s += 10)
            for (int a = 0; a <= 90; a += 30)
              run_chk(s, a, cs[ci], ps[pi], rev, 1'b0, 0, 0, 0);

    // R4 overflow corners with full-scale values
    run_chk(25, 70, 600, 1, 1, 1'b0, 0, 0, 0);
    run_chk(25, 70, 600, 1, 3, 1'b0, 0, 0, 0);
    run_chk(0, 0, 65535, 1, 2, 1'b0, 0, 0, 0);
    run_chk(65535, 65535, 65535, 2, 0, 1'b0, 0, 0, 0);
    run_chk(70, 165, 600, 30, 2, 1'b0, 0, 0, 0);

    // R7 merge with channel mate
    run_chk(70, 165, 600, 30, 2, 1'b1, 5, 16, 3);
    run_chk(90, 290, 383, 30, 1, 1'b1, 2, 3, 16);
    run_chk(30, 80, 120, 30, 2, 1'b1, 3, 2, 1);
    run_chk(30, 80, 120, 30, 2, 1'b0, 5, 16, 16);
    run_chk(10, 10, 30, 30, 1, 1'b1, 4, 2, 2);

    // R10 zero period
    run_chk(30, 80, 120, 30, 2, 1'b0, 0, 0, 0);
    @(negedge clk);
    drive(90, 290, 600, 0, 1, 1'b0, 0, 0, 0);
    start = 1'b1;
    wait_done(seen);
    chk("R10 err raised", int'(err), 1);
    chk("R10 setup held", int'(setup_cnt), e_s);
    chk("R10 active held", int'(active_cnt), e_a);
    chk("R10 recov held", int'(recov_cnt), e_r);
    chk("R10 byte held", int'(drw_byte), e_byte);
    run_chk(90, 290, 600, 30, 1, 1'b0, 0, 0, 0);
    chk("R10 err cleared", int'(err), 0);

    // R11 start while busy is ignored
    @(negedge clk);
    drive(25, 70, 120, 30, 1, 1'b0, 0, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy", int'(busy), 1);
    repeat (5) @(negedge clk);
    drive(90, 290, 600, 7, 2, 1'b0, 0, 0, 0);
    start = 1'b1;
    wait_done(seen);
    model(25, 70, 120, 30, 1, 1'b0, 0, 0, 0);
    chk("R11 first request kept setup", int'(setup_cnt), e_s);
    chk("R11 first request kept byte", int'(drw_byte), e_byte);
    @(negedge clk);
    chk("R11 done one cycle", int'(done), 0);
    seen = 1'b0;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk("R11 no second completion", int'(seen), 0);
    chk("R11 idle after", int'(busy), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule